// File: doc/BRIEF.md
# Device-Side Command Mailbox Registers

This block is the device end of a host-to-device command mailbox. A host reaches it over a plain 64-bit register bus. To issue a command, the host writes an opcode and an input length into the command register and fills a payload window. It then sets a doorbell bit. While the doorbell is set, the block offers the command to a local executor through a valid/done handshake. The executor can read and write the same payload store through a port of its own.

When the executor pulses done, the block does three things at one clock edge. It stores the return code in the status register. On success it replaces the length field of the command register with the output length. It clears the doorbell. The host polls the doorbell until it reads clear, then collects the return code, the output length and the output payload.

Until completion, the host cannot disturb the command or the payload, because writes to both are locked out.

Top module: `mbox_regs`

## Requirements
- R1: After reset the doorbell, the command register and the status register read zero, `exec_valid_o` is low and `rsp_valid_o` is low.
- R2: A read request returns its data with `rsp_valid_o` high exactly one cycle later. The read map is:
  - byte address 0x04: doorbell in bit 0;
  - 0x08: command register, opcode in bits 15:0 and length in bits 16+LEN_W-1:16;
  - 0x10: status register, return code in bits 47:32;
  - 0x20 upward: payload words, one per 8 bytes;
  - any other address reads zero.
- R3: A host write to 0x04 with bit 0 set, while the doorbell is clear, sets the doorbell. From the next cycle `exec_valid_o` is high and shows the stored opcode and length.
- R4: A host write of 0 to the doorbell bit leaves the doorbell unchanged.
- R5: While the doorbell is set, host writes to the command register and the payload window are dropped, and the executor's opcode and length stay stable.
- R6: An `exec_done_i` pulse while the doorbell is set clears the doorbell and loads `exec_rc_i` into the status register at the same edge.
- R7: At that edge, the length field of the command register takes `exec_out_len_i` only when the return code is zero. A nonzero return code leaves the length unchanged. The opcode is kept in both cases.
- R8: The payload window is BUF_WORDS 64-bit words (32 by default, 0x20 to 0x11F). Reads above it return zero, and writes above it change no word.
- R9: The executor port writes payload words, and the host then reads them. The executor port also reads words that the host wrote.
- R10: An `exec_done_i` pulse while the doorbell is clear changes neither the status register nor the command register.
- R11: The background status location 0x18 reads zero, including after a host write to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Bus request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata_o | output | 64 | Read data |
| exec_valid_o | output | 1 | Command pending for the executor |
| exec_opcode_o | output | 16 | Pending opcode |
| exec_len_o | output | LEN_W | Pending input length |
| exec_done_i | input | 1 | Executor completion pulse |
| exec_rc_i | input | 16 | Return code, sampled with done |
| exec_out_len_i | input | LEN_W | Output length, sampled with done |
| exec_buf_we_i | input | 1 | Executor payload write enable |
| exec_buf_addr_i | input | BUF_AW | Executor payload word index |
| exec_buf_wdata_i | input | 64 | Executor payload write data |
| exec_buf_rdata_o | output | 64 | Executor payload read data |

## Verification
The hardest state to reach from the ports is a command in flight that receives hostile host traffic before completion. That traffic includes command rewrites, payload writes, a zero doorbell write and a second ring. The bench plays the executor itself and holds `exec_done_i` low for as long as it needs. It drives that traffic and checks the frozen executor view and the unchanged payload. Only after that does it release done, with either a zero or a nonzero return code. A stray done pulse while the mailbox is idle and writes just past the payload window complete the picture.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int DATA_W  = 64;
  localparam int OPC_W   = 16;
  localparam int RC_W    = 16;
  localparam int LEN_LSB = 16;
  localparam int RC_LSB  = 32;

  localparam int OFF_CTRL = 'h04;
  localparam int OFF_CMD  = 'h08;
  localparam int OFF_STAT = 'h10;
  localparam int OFF_BG   = 'h18;
  localparam int OFF_PAY  = 'h20;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_CMD,
    SEL_STAT,
    SEL_BG,
    SEL_BUF
  } reg_sel_e;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int BUF_WORDS = 32,
  localparam int BUF_AW   = $clog2(BUF_WORDS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic [BUF_AW-1:0] idx_o
);
  localparam logic [ADDR_W-1:0] PayBase = ADDR_W'(OFF_PAY);
  localparam logic [ADDR_W-1:0] PayEnd  = ADDR_W'(OFF_PAY + BUF_WORDS * 8);

  logic [ADDR_W-1:0] off;

  always_comb begin
    off   = addr_i - PayBase;
    idx_o = BUF_AW'(off >> 3);
    if      (addr_i == ADDR_W'(OFF_CTRL))            sel_o = SEL_CTRL;
    else if (addr_i == ADDR_W'(OFF_CMD))             sel_o = SEL_CMD;
    else if (addr_i == ADDR_W'(OFF_STAT))            sel_o = SEL_STAT;
    else if (addr_i == ADDR_W'(OFF_BG))              sel_o = SEL_BG;
    else if (addr_i >= PayBase && addr_i < PayEnd)   sel_o = SEL_BUF;
    else                                             sel_o = SEL_NONE;
  end
endmodule

// File: rtl/mbox_buf.sv
module mbox_buf
  import mbox_pkg::*;
#(
  parameter int BUF_WORDS = 32,
  localparam int BUF_AW   = $clog2(BUF_WORDS)
) (
  input  logic              clk_i,
  input  logic              host_we_i,
  input  logic [BUF_AW-1:0] host_idx_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              exec_we_i,
  input  logic [BUF_AW-1:0] exec_idx_i,
  input  logic [DATA_W-1:0] exec_wdata_i,
  output logic [DATA_W-1:0] exec_rdata_o
);
  logic [DATA_W-1:0] mem [BUF_WORDS];

  // per-word write ports: executor wins a same-word collision
  for (genvar w = 0; w < BUF_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i) begin
      if (exec_we_i && exec_idx_i == BUF_AW'(w))
        mem[w] <= exec_wdata_i;
      else if (host_we_i && host_idx_i == BUF_AW'(w))
        mem[w] <= host_wdata_i;
    end
  end

  always_comb begin
    host_rdata_o = '0;
    exec_rdata_o = '0;
    if (int'(host_idx_i) < BUF_WORDS) host_rdata_o = mem[host_idx_i];
    if (int'(exec_idx_i) < BUF_WORDS) exec_rdata_o = mem[exec_idx_i];
  end
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int LEN_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  reg_sel_e         sel_i,
  input  logic             db_bit_i,
  input  logic [OPC_W-1:0] opc_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             done_i,
  input  logic [RC_W-1:0]  rc_i,
  input  logic [LEN_W-1:0] out_len_i,
  output logic             doorbell_o,
  output logic [OPC_W-1:0] opc_o,
  output logic [LEN_W-1:0] len_o,
  output logic [RC_W-1:0]  rc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      doorbell_o <= 1'b0;
      opc_o      <= '0;
      len_o      <= '0;
      rc_o       <= '0;
    end else if (doorbell_o) begin
      // busy: host side locked, only completion acts
      if (done_i) begin
        doorbell_o <= 1'b0;
        rc_o       <= rc_i;
        if (rc_i == '0) len_o <= out_len_i;
      end
    end else if (wr_i) begin
      if (sel_i == SEL_CTRL && db_bit_i) doorbell_o <= 1'b1;
      if (sel_i == SEL_CMD) begin
        opc_o <= opc_i;
        len_o <= len_i;
      end
    end
  end
endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
  import mbox_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int LEN_W     = 21,
  parameter int BUF_WORDS = 32,
  localparam int BUF_AW   = $clog2(BUF_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [63:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [63:0]       rsp_rdata_o,
  output logic              exec_valid_o,
  output logic [15:0]       exec_opcode_o,
  output logic [LEN_W-1:0]  exec_len_o,
  input  logic              exec_done_i,
  input  logic [15:0]       exec_rc_i,
  input  logic [LEN_W-1:0]  exec_out_len_i,
  input  logic              exec_buf_we_i,
  input  logic [BUF_AW-1:0] exec_buf_addr_i,
  input  logic [63:0]       exec_buf_wdata_i,
  output logic [63:0]       exec_buf_rdata_o
);
  reg_sel_e          sel;
  logic [BUF_AW-1:0] buf_idx;
  logic              wr, rd;
  logic              doorbell;
  logic [OPC_W-1:0]  opc;
  logic [LEN_W-1:0]  len;
  logic [RC_W-1:0]   rc;
  logic [63:0]       buf_rdata, rd_mux;

  assign wr = req_valid_i &&  req_write_i;
  assign rd = req_valid_i && !req_write_i;

  mbox_decode #(.ADDR_W(ADDR_W), .BUF_WORDS(BUF_WORDS)) u_dec (
    .addr_i (req_addr_i),
    .sel_o  (sel),
    .idx_o  (buf_idx)
  );

  mbox_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr),
    .sel_i     (sel),
    .db_bit_i  (req_wdata_i[0]),
    .opc_i     (req_wdata_i[OPC_W-1:0]),
    .len_i     (req_wdata_i[LEN_LSB+LEN_W-1:LEN_LSB]),
    .done_i    (exec_done_i),
    .rc_i      (exec_rc_i),
    .out_len_i (exec_out_len_i),
    .doorbell_o(doorbell),
    .opc_o     (opc),
    .len_o     (len),
    .rc_o      (rc)
  );

  mbox_buf #(.BUF_WORDS(BUF_WORDS)) u_buf (
    .clk_i       (clk_i),
    .host_we_i   (wr && sel == SEL_BUF && !doorbell),
    .host_idx_i  (buf_idx),
    .host_wdata_i(req_wdata_i),
    .host_rdata_o(buf_rdata),
    .exec_we_i   (exec_buf_we_i),
    .exec_idx_i  (exec_buf_addr_i),
    .exec_wdata_i(exec_buf_wdata_i),
    .exec_rdata_o(exec_buf_rdata_o)
  );

  always_comb begin
    unique case (sel)
      SEL_CTRL: rd_mux = {63'd0, doorbell};
      SEL_CMD:  rd_mux = (64'(len) << LEN_LSB) | 64'(opc);
      SEL_STAT: rd_mux = 64'(rc) << RC_LSB;
      SEL_BUF:  rd_mux = buf_rdata;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= rd;
      if (rd) rsp_rdata_o <= rd_mux;
    end
  end

  assign exec_valid_o  = doorbell;
  assign exec_opcode_o = opc;
  assign exec_len_o    = len;
endmodule

// File: rtl/mbox_regs_chk.sv
module mbox_regs_chk
  import mbox_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int LEN_W     = 21,
  parameter int BUF_WORDS = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              db_bit_i,
  input logic              rsp_valid_o,
  input logic [63:0]       rsp_rdata_o,
  input logic              exec_valid_o,
  input logic [15:0]       exec_opcode_o,
  input logic [LEN_W-1:0]  exec_len_o,
  input logic              exec_done_i
);
  localparam logic [ADDR_W-1:0] PayEnd = ADDR_W'(OFF_PAY + BUF_WORDS * 8);

  logic ring;
  assign ring = req_valid_i && req_write_i && req_addr_i == ADDR_W'(OFF_CTRL) && db_bit_i;

  assert_rd_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> rsp_valid_o);
  assert_no_spurious_rsp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !req_write_i) |=> !rsp_valid_o);
  assert_idle_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exec_valid_o && !ring) |=> !exec_valid_o);
  assert_busy_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_valid_o && !exec_done_i) |=> (exec_valid_o && $stable(exec_opcode_o) && $stable(exec_len_o)));
  assert_done_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_valid_o && exec_done_i) |=> !exec_valid_o);
  assert_above_window_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && $past(req_addr_i) >= PayEnd) |-> rsp_rdata_o == 64'd0);
  assert_bg_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && $past(req_addr_i) == ADDR_W'(OFF_BG)) |-> rsp_rdata_o == 64'd0);
endmodule

bind mbox_regs mbox_regs_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUF_WORDS(BUF_WORDS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_write_i  (req_write_i),
  .req_addr_i   (req_addr_i),
  .db_bit_i     (req_wdata_i[0]),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_rdata_o  (rsp_rdata_o),
  .exec_valid_o (exec_valid_o),
  .exec_opcode_o(exec_opcode_o),
  .exec_len_o   (exec_len_o),
  .exec_done_i  (exec_done_i)
);

// File: tb/sim_mbox_regs.sv
module sim_mbox_regs;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int LEN_W  = 21;
  localparam int BUF_AW = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [63:0]       req_wdata = '0;
  logic              rsp_valid;
  logic [63:0]       rsp_rdata;
  logic              exec_valid;
  logic [15:0]       exec_opcode;
  logic [LEN_W-1:0]  exec_len;
  logic              exec_done = 1'b0;
  logic [15:0]       exec_rc = '0;
  logic [LEN_W-1:0]  exec_out_len = '0;
  logic              exec_buf_we = 1'b0;
  logic [BUF_AW-1:0] exec_buf_addr = '0;
  logic [63:0]       exec_buf_wdata = '0;
  logic [63:0]       exec_buf_rdata;

  int errors = 0;
  int checks = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_regs u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .exec_valid_o(exec_valid), .exec_opcode_o(exec_opcode), .exec_len_o(exec_len),
    .exec_done_i(exec_done), .exec_rc_i(exec_rc), .exec_out_len_i(exec_out_len),
    .exec_buf_we_i(exec_buf_we), .exec_buf_addr_i(exec_buf_addr),
    .exec_buf_wdata_i(exec_buf_wdata), .exec_buf_rdata_o(exec_buf_rdata)
  );

  function automatic logic [63:0] cmd_word(input logic [15:0] opc, input logic [LEN_W-1:0] len);
    return (64'(len) << 16) | 64'(opc);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [63:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [63:0] d);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    if (rsp_valid !== 1'b1) begin
      errors++; checks++;
      $display("FAIL R2 rsp_valid actual=%b expected=1", rsp_valid);
    end
    d = rsp_rdata;
  endtask

  task automatic finish_cmd(input logic [15:0] rc, input logic [LEN_W-1:0] olen);
    exec_done = 1; exec_rc = rc; exec_out_len = olen;
    @(negedge clk);
    exec_done = 0;
  endtask

  task automatic t_reset();
    logic [63:0] d;
    check("R1 exec_valid", 64'(exec_valid), 0);
    check("R1 rsp_valid", 64'(rsp_valid), 0);
    bus_rd(12'h004, d); check("R1 doorbell", d, 0);
    bus_rd(12'h008, d); check("R1 command", d, 0);
    bus_rd(12'h010, d); check("R1 status", d, 0);
  endtask

  task automatic t_regs();
    logic [63:0] d;
    bus_wr(12'h008, cmd_word(16'h1234, 21'd5) | 64'hF000_0000_0000_0000);
    bus_rd(12'h008, d); check("R2 command map", d, cmd_word(16'h1234, 21'd5));
    bus_wr(12'h004, 64'h0);
    check("R4 zero write", 64'(exec_valid), 0);
    bus_rd(12'h004, d); check("R4 doorbell read", d, 0);
    bus_wr(12'h018, 64'hDEAD_BEEF_0000_0001);
    bus_rd(12'h018, d); check("R11 bg status", d, 0);
    bus_rd(12'h200, d); check("R2 unmapped", d, 0);
  endtask

  task automatic t_payload();
    logic [63:0] d;
    bus_wr(12'h020, 64'h0123_4567_89AB_CDEF);
    bus_wr(12'h118, 64'hFEED_0000_0000_0031);
    bus_rd(12'h020, d); check("R2 word 0", d, 64'h0123_4567_89AB_CDEF);
    bus_rd(12'h118, d); check("R8 last word", d, 64'hFEED_0000_0000_0031);
    bus_wr(12'h120, 64'h5555_AAAA_5555_AAAA);
    bus_rd(12'h120, d); check("R8 above window", d, 0);
    bus_rd(12'h020, d); check("R8 no alias word 0", d, 64'h0123_4567_89AB_CDEF);
    exec_buf_addr = 5'd31; #1;
    check("R9 exec reads host word", exec_buf_rdata, 64'hFEED_0000_0000_0031);
  endtask

  task automatic t_submit_ok();
    logic [63:0] d;
    bus_wr(12'h008, cmd_word(16'hABCD, 21'd3));
    bus_wr(12'h004, 64'h1);
    check("R3 valid", 64'(exec_valid), 1);
    check("R3 opcode", 64'(exec_opcode), 64'hABCD);
    check("R3 length", 64'(exec_len), 3);
    bus_wr(12'h008, cmd_word(16'h1111, 21'd9));
    bus_wr(12'h020, 64'h0);
    bus_wr(12'h004, 64'h0);
    check("R4 zero write while busy", 64'(exec_valid), 1);
    check("R5 opcode frozen", 64'(exec_opcode), 64'hABCD);
    check("R5 length frozen", 64'(exec_len), 3);
    bus_rd(12'h020, d); check("R5 payload locked", d, 64'h0123_4567_89AB_CDEF);
    bus_rd(12'h004, d); check("R3 doorbell reads set", d, 1);
    exec_buf_we = 1; exec_buf_addr = 5'd2; exec_buf_wdata = 64'hC0DE_0000_0000_0002;
    @(negedge clk);
    exec_buf_we = 0;
    finish_cmd(16'h0000, 21'h40);
    check("R6 valid drops", 64'(exec_valid), 0);
    bus_rd(12'h004, d); check("R6 doorbell clear", d, 0);
    bus_rd(12'h010, d); check("R6 status rc zero", d, 0);
    bus_rd(12'h008, d); check("R7 out length", d, cmd_word(16'hABCD, 21'h40));
    bus_rd(12'h030, d); check("R9 exec written word", d, 64'hC0DE_0000_0000_0002);
  endtask

  task automatic t_submit_err();
    logic [63:0] d;
    bus_wr(12'h008, cmd_word(16'h0042, 21'd7));
    bus_wr(12'h004, 64'h1);
    check("R3 second ring", 64'(exec_valid), 1);
    finish_cmd(16'h0017, 21'h99);
    bus_rd(12'h010, d); check("R6 status rc", d, 64'h0000_0017_0000_0000);
    bus_rd(12'h008, d); check("R7 length kept on error", d, cmd_word(16'h0042, 21'd7));
  endtask

  task automatic t_stray_done();
    logic [63:0] d;
    finish_cmd(16'h0000, 21'h5);
    check("R10 stays idle", 64'(exec_valid), 0);
    bus_rd(12'h010, d); check("R10 status kept", d, 64'h0000_0017_0000_0000);
    bus_rd(12'h008, d); check("R10 command kept", d, cmd_word(16'h0042, 21'd7));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_payload();
    t_submit_ok();
    t_submit_err();
    t_stray_done();
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule